// File: doc/BRIEF.md
# I2C Bit-Rate Tick Generator

This block derives the sub-bit timing strobes for an I2C master from a fast system clock. A seven-bit divider word carries a three-bit exponent field and a four-bit linear field. The system clock is first divided by a power of two set by the exponent. The result is then divided by one more than the linear field. Each resulting strobe marks the start of one of ten sub-phases, and ten sub-phases make one SCL period. A separate bit engine uses the phase index to place SCL edges, sample SDA and time START and STOP conditions.

Software chooses the exponent in 0..7 and the linear field in 0..15. It takes the pair that gives the fastest SCL rate not above the requested rate, which is 100 kHz by default. In the default build the prescale is two to the power (exponent + 1). A build parameter selects a variant in which the prescale is two to the power of the exponent itself. A divider word written while the generator runs is held back until the next SCL period begins. No period is ever cut short.

Top module: `i2c_tick_gen`

## Requirements
- R1: After reset, `tick` is 0 and `phase` is 0, and they stay so while `enable` is low.
- R2: The exponent field is `div_cfg[2:0]` and the linear field is `div_cfg[6:3]`. In the default build, the sub-phase interval is (linear+1) × 2^(exponent+1) system clocks, and the first `tick` after `enable` rises comes exactly that many cycles after the rising edge.
- R3: `tick` is a pulse one system clock wide. It is low in the cycle after a tick whenever the interval is longer than one cycle.
- R4: `phase` advances by one on each `tick`, counting 0,1,...,9 and then back to 0. It is 1 during the first tick after enabling, it never exceeds 9, and it does not change between ticks.
- R5: Taking `enable` low stops the ticks and returns `phase` to 0 by the next cycle. No tick occurs while `enable` stays low.
- R6: A change to `div_cfg` while enabled takes effect only after the tick that returns `phase` to 0. While disabled, the value present on `div_cfg` is the one used once `enable` rises.
- R7: With `EXP_PLUS_ONE` = 0, the sub-phase interval is (linear+1) × 2^exponent cycles. The smallest setting gives a tick on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run the generator; low clears the counters and loads the divider |
| div_cfg | input | 7 | Divider word: [2:0] exponent, [6:3] linear factor |
| tick | output | 1 | One-cycle strobe at each sub-phase boundary |
| phase | output | 4 | Index 0..9 of the current sub-phase |

## Verification
Every one of the 128 divider words is swept in both builds, and the first-tick latency is compared with the closed-form interval. A design that swapped the fields, dropped the +1 on either factor, or was off by one cycle in the prescaler fails many of these points. The smallest alternative setting checks that back-to-back ticks still work. A divider word is changed in the middle of a period to catch a design that applies it at once: such a design shortens the remaining sub-phases. Long runs check the 9-to-0 wrap and the pulse width, and dropping `enable` mid-run checks that the phase clears and the ticks stop.

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int N_W          = 3,
  parameter int M_W          = 4,
  parameter int PHASES       = 10,
  parameter bit EXP_PLUS_ONE = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic [N_W+M_W-1:0]            div_cfg,
  output logic                          tick,
  output logic [$clog2(PHASES)-1:0]     phase
);

  localparam int PH_W  = $clog2(PHASES);
  localparam int PRE_W = 1 << N_W;
  localparam int SH_W  = N_W + 1;
  localparam logic [SH_W-1:0] SH_ADD = EXP_PLUS_ONE ? SH_W'(1) : SH_W'(0);
  localparam logic [PH_W-1:0] LAST   = PH_W'(PHASES - 1);

  logic [N_W-1:0]   n_act;
  logic [M_W-1:0]   m_act;
  logic [PRE_W-1:0] pre;
  logic [M_W-1:0]   lin;

  wire [SH_W-1:0]  shamt   = {1'b0, n_act} + SH_ADD;
  wire [PRE_W-1:0] pre_lim = (PRE_W'(1) << shamt) - PRE_W'(1);
  wire pre_end = (pre == pre_lim);
  wire lin_end = (lin == m_act);
  wire fire    = enable && pre_end && lin_end;
  wire wrap    = fire && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      lin   <= '0;
      phase <= '0;
      tick  <= 1'b0;
      n_act <= '0;
      m_act <= '0;
    end else begin
      tick <= fire;
      if (!enable) begin
        pre   <= '0;
        lin   <= '0;
        phase <= '0;
        n_act <= div_cfg[N_W-1:0];
        m_act <= div_cfg[N_W+M_W-1:N_W];
      end else begin
        if (pre_end) begin
          pre <= '0;
          lin <= lin_end ? '0 : lin + M_W'(1);
        end else begin
          pre <= pre + PRE_W'(1);
        end
        if (fire)
          phase <= (phase == LAST) ? '0 : phase + PH_W'(1);
        if (wrap) begin
          n_act <= div_cfg[N_W-1:0];
          m_act <= div_cfg[N_W+M_W-1:N_W];
        end
      end
    end
  end

  a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);

  a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> phase == (($past(phase) == LAST) ? PH_W'(0) : $past(phase) + PH_W'(1)));

  a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !tick) |-> $stable(phase));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!tick && phase == '0));

  a_r6_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(n_act) || !$stable(m_act)) |-> phase == '0);

endmodule

// File: tb/test_i2c_tick_gen.sv
module test_i2c_tick_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [6:0] div_cfg = '0;
  logic tick, tick_a;
  logic [3:0] phase, phase_a;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_tick_gen i_i2c_tick_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg),
    .tick(tick), .phase(phase));

  i2c_tick_gen #(.EXP_PLUS_ONE(1'b0)) i_i2c_tick_gen_alt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg),
    .tick(tick_a), .phase(phase_a));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int cyc);
    cyc = -1;
    for (int k = 1; k <= 5000; k++) begin
      @(negedge clk);
      if (tick) begin cyc = k; break; end
    end
  endtask

  task automatic restart(input logic [3:0] m, input logic [2:0] n);
    @(negedge clk);
    enable = 1'b0;
    div_cfg = {m, n};
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    int c, gm, ga, pm, pa;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(tick == 0 && tick_a == 0, "R1 tick", int'(tick), 0);
    check(phase == 0, "R1 phase", int'(phase), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(tick == 0 && phase == 0, "R1 idle after reset", int'(phase), 0);

    // R2, R7: sweep all divider words in both builds
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 16; m++) begin
        restart(4'(m), 3'(n));
        pm = (m + 1) << (n + 1);
        pa = (m + 1) << n;
        gm = 0; ga = 0;
        for (int k = 1; k <= pm + 2; k++) begin
          @(negedge clk);
          if (tick && gm == 0) begin
            gm = k;
            if (n == 0) check(phase == 1, "R4 first phase", int'(phase), 1);
          end
          if (tick_a && ga == 0) ga = k;
        end
        check(gm == pm, "R2 interval", gm, pm);
        check(ga == pa, "R7 alt interval", ga, pa);
      end
    end

    // R7: fastest alternative setting ticks every cycle
    restart(4'd0, 3'd0);
    @(negedge clk);
    c = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick_a) c++;
    end
    check(c == 20, "R7 back-to-back ticks", c, 20);

    // R3, R4: long run, pulse width and phase wrap
    restart(4'd2, 3'd1);
    wait_tick(c);
    check(c == 12, "R2 first tick", c, 12);
    for (int t = 2; t <= 25; t++) begin
      @(negedge clk);
      check(tick == 0, "R3 one-cycle pulse", int'(tick), 0);
      wait_tick(c);
      check(c == 11, "R2 steady interval", c + 1, 12);
      check(int'(phase) == t % 10, "R4 phase sequence", int'(phase), t % 10);
    end

    // R6: divider change mid period waits for phase 0
    restart(4'd1, 3'd0);
    for (int t = 0; t < 3; t++) wait_tick(c);
    div_cfg = {4'd3, 3'd0};
    for (int t = 0; t < 7; t++) begin
      wait_tick(c);
      check(c == 4, "R6 old divider kept", c, 4);
    end
    check(phase == 0, "R6 wrap reached", int'(phase), 0);
    wait_tick(c);
    check(c == 8, "R6 new divider after wrap", c, 8);

    // R5: disable mid run
    wait_tick(c);
    wait_tick(c);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(phase == 0, "R5 phase cleared", int'(phase), 0);
    c = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (tick || phase != 0) c++;
    end
    check(c == 0, "R5 quiet while disabled", c, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule